// File: doc/BRIEF.md
# Midplane Slot Control and Status Registers

This block is a small memory-mapped register file for a router midplane. A CPU reaches it over a simple synchronous bus with an 8-bit offset, separate read and write strobes, and 32-bit write and read data. Read data is registered and appears on the cycle after the read strobe. The block has four jobs. It reports which port-adapter bays are powered, using a scattered two-bit power-good code for each bay. It collects card insertion and removal events and SRAM error events into a status word that software clears by writing 1s. It raises and holds three interrupt lines until software acknowledges them through particular register accesses. It also gives software bit-level control of the serial configuration EEPROMs in seven bays.

The EEPROM lines of the seven bays are split across two 32-bit ports. Each port has four 8-bit lanes, and the bays are not assigned to lanes in numeric order. Software toggles select, clock and data-in by writing a port. Reading a port returns those three driven values together with each bay's live data-out line.

Top module: `midplane_slot_regs`

## Requirements
- R1: After reset, all interrupt outputs, `ctrl_o`, every EEPROM output and `rdata_o` are zero.
- R2: A read at 0x50 returns the power-good word. Bits 2:1 (bay 0) are always 1. The pairs for bays 1 to 6 are set only when `card_present_i[bay]` is 1: bay 1 uses 10:9, bay 2 uses 14:13, bay 3 uses 26:25, bay 4 uses 18:17, bay 5 uses 30:29 and bay 6 uses 22:21. All other bits are 0.
- R3: A read at 0x40 returns the power-good word ANDed with 0x66666600. Any access to 0x40, read or write, clears `pa_irq_o`.
- R4: The event status word is read at 0x70 as bits 7:0, with bits 31:8 reading 0. `oir_evt_i[k]` sets bit k for k = 1..6, and `sram_err_i` sets bit 7. Bit 0 is always 0. Reading the word does not change it.
- R5: A write to 0x70 clears each status bit whose write-data bit is 1. Any access to 0x70, read or write, clears `oir_irq_o`.
- R6: Each interrupt is set on a rising edge of its event input or inputs, one cycle later, and stays set until its clearing access. If a rising event and a clearing access fall in the same cycle, the interrupt is set. An event input that stays high does not set the interrupt again.
- R7: Reads at 0x10 to 0x13 and 0x18 to 0x1A return 0xFFFFFFFF and clear `netio_irq_o`. Other offsets, such as 0x14 and 0x1B, do not clear it.
- R8: Offset 0x58 is a 32-bit read/write control register, and its value drives `ctrl_o`.
- R9: A write to 0x60 drives bays 0, 1, 4 and 3 from lanes 0, 1, 2 and 3 (lane n is bits 8n+7:8n). A write to 0x68 drives bays 2, 6 and 5 from lanes 1, 2 and 3. Within a lane, bit 1 is select, bit 3 is clock and bit 4 is data-in. All other written bits have no effect.
- R10: A read of an EEPROM port returns each of its bays' stored select, clock and data-in bits at the same lane positions, and the bay's live `ee_dout_i` at lane bit 6. All other bits read 0.
- R11: A read at 0x48 returns 0xFFFFFFFF. A read at 0x78 returns 0, and writes to 0x78 change nothing. Every offset not listed above reads 0.
- R12: `rdata_o` shows the read value on the cycle after `rd_en_i`, and is 0 on the cycle after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register offset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| card_present_i | input | 6 | Card present, bays 6..1 |
| oir_evt_i | input | 6 | Insertion/removal event, slots 6..1 |
| sram_err_i | input | 1 | SRAM error event |
| netio_evt_i | input | 1 | Network I/O interrupt event |
| pa_mgmt_evt_i | input | 1 | Adapter management interrupt event |
| ee_dout_i | input | 7 | EEPROM data-out, bays 6..0 |
| netio_irq_o | output | 1 | Network I/O interrupt |
| pa_irq_o | output | 1 | Adapter management interrupt |
| oir_irq_o | output | 1 | Insertion/removal interrupt |
| ctrl_o | output | 32 | Control register value |
| ee_sel_o | output | 7 | EEPROM select, bays 6..0 |
| ee_clk_o | output | 7 | EEPROM clock, bays 6..0 |
| ee_din_o | output | 7 | EEPROM data-in, bays 6..0 |

## Verification
Two things can land in the same cycle: an interrupt's rising event and the software access that acknowledges it. An event bit can likewise arrive in the same cycle as a write-1-to-clear of the event status. The bench provokes both cases. It raises `pa_mgmt_evt_i` in the same cycle as a write to 0x40, and it raises `oir_evt_i[6]` in the same cycle as a write to 0x70 whose data has bit 6 set. In each case it expects the interrupt to stay set and the new status bit to survive the clear. It reads 0x70 afterwards to confirm the status value.

// File: rtl/mpsr_pkg.sv
package mpsr_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int NUM_BAYS = 7;
  localparam int NUM_PORT = 2;
  localparam int LANE_W   = 8;
  localparam int EVT_W    = 8;

  localparam int EE_SEL  = 1;
  localparam int EE_CLK  = 3;
  localparam int EE_DIN  = 4;
  localparam int EE_DOUT = 6;

  localparam logic [ADDR_W-1:0] OFF_MGMT  = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_ONES  = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_PWR   = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h58;
  localparam logic [ADDR_W-1:0] OFF_EE0   = 8'h60;
  localparam logic [ADDR_W-1:0] OFF_EE1   = 8'h68;
  localparam logic [ADDR_W-1:0] OFF_EVT   = 8'h70;
  localparam logic [ADDR_W-1:0] OFF_ERREN = 8'h78;

  localparam logic [DATA_W-1:0] MGMT_MASK = 32'h6666_6600;

  // port that carries a bay's EEPROM lines
  function automatic int bay_port(input int b);
    return (b == 2 || b == 5 || b == 6) ? 1 : 0;
  endfunction

  // lane inside that port
  function automatic int bay_lane(input int b);
    case (b)
      0:       return 0;
      1, 2:    return 1;
      4, 6:    return 2;
      default: return 3;
    endcase
  endfunction

  // low bit of a bay's power-good pair
  function automatic int bay_pwr_lo(input int b);
    case (b)
      0:       return 1;
      1:       return 9;
      2:       return 13;
      3:       return 25;
      4:       return 17;
      5:       return 29;
      default: return 21;
    endcase
  endfunction

  function automatic logic is_netio_off(input logic [ADDR_W-1:0] a);
    return (a >= 8'h10 && a <= 8'h13) || (a >= 8'h18 && a <= 8'h1a);
  endfunction
endpackage

// File: rtl/mpsr_irq_latch.sv
module mpsr_irq_latch #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic         irq_o
);
  logic [W-1:0] evt_q;
  logic         rise;

  assign rise = |(evt_i & ~evt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      evt_q <= evt_i;
      if (rise)       irq_o <= 1'b1;  // event beats a same-cycle clear
      else if (clr_i) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mpsr_evt_status.sv
module mpsr_evt_status #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         w1c_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] clr;

  assign clr = w1c_i ? mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= (status_o & ~clr) | set_i;
  end
endmodule

// File: rtl/mpsr_ee_ports.sv
module mpsr_ee_ports
  import mpsr_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_PORT-1:0]              wr_port_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [NUM_BAYS-1:0]              dout_i,
  output logic [NUM_BAYS-1:0]              sel_o,
  output logic [NUM_BAYS-1:0]              clk_o,
  output logic [NUM_BAYS-1:0]              din_o,
  output logic [NUM_PORT-1:0][DATA_W-1:0]  rd_port_o
);
  localparam int NUM_LANE = DATA_W / LANE_W;

  for (genvar b = 0; b < NUM_BAYS; b++) begin : g_bay
    localparam int P    = bay_port(b);
    localparam int BASE = bay_lane(b) * LANE_W;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_o[b] <= 1'b0;
        clk_o[b] <= 1'b0;
        din_o[b] <= 1'b0;
      end else if (wr_port_i[P]) begin
        sel_o[b] <= wdata_i[BASE+EE_SEL];
        clk_o[b] <= wdata_i[BASE+EE_CLK];
        din_o[b] <= wdata_i[BASE+EE_DIN];
      end
    end
  end

  always_comb begin
    rd_port_o = '0;
    for (int b = 0; b < NUM_BAYS; b++) begin
      rd_port_o[bay_port(b)][bay_lane(b)*LANE_W+EE_SEL]  = sel_o[b];
      rd_port_o[bay_port(b)][bay_lane(b)*LANE_W+EE_CLK]  = clk_o[b];
      rd_port_o[bay_port(b)][bay_lane(b)*LANE_W+EE_DIN]  = din_o[b];
      rd_port_o[bay_port(b)][bay_lane(b)*LANE_W+EE_DOUT] = dout_i[b];
    end
  end

  // bits outside the driven lane positions are dropped
  logic [DATA_W-1:0] used_mask;
  logic              unused_wdata;
  always_comb begin
    used_mask = '0;
    for (int l = 0; l < NUM_LANE; l++) begin
      used_mask[l*LANE_W+EE_SEL] = 1'b1;
      used_mask[l*LANE_W+EE_CLK] = 1'b1;
      used_mask[l*LANE_W+EE_DIN] = 1'b1;
    end
  end
  assign unused_wdata = ^(wdata_i & ~used_mask);
endmodule

// File: rtl/midplane_slot_regs.sv
module midplane_slot_regs
  import mpsr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_BAYS-1:1] card_present_i,
  input  logic [NUM_BAYS-1:1] oir_evt_i,
  input  logic                sram_err_i,
  input  logic                netio_evt_i,
  input  logic                pa_mgmt_evt_i,
  input  logic [NUM_BAYS-1:0] ee_dout_i,
  output logic                netio_irq_o,
  output logic                pa_irq_o,
  output logic                oir_irq_o,
  output logic [DATA_W-1:0]   ctrl_o,
  output logic [NUM_BAYS-1:0] ee_sel_o,
  output logic [NUM_BAYS-1:0] ee_clk_o,
  output logic [NUM_BAYS-1:0] ee_din_o
);
  logic                            acc;
  logic                            mgmt_clr, netio_clr, evt_acc, evt_w1c;
  logic [NUM_PORT-1:0]             ee_wr;
  logic [NUM_PORT-1:0][DATA_W-1:0] ee_rd;
  logic [DATA_W-1:0]               pwr_word;
  logic [EVT_W-1:0]                evt_set, evt_status;
  logic [DATA_W-1:0]               rd_mux;

  assign acc       = rd_en_i | wr_en_i;
  assign mgmt_clr  = acc && (addr_i == OFF_MGMT);
  assign netio_clr = rd_en_i && is_netio_off(addr_i);
  assign evt_acc   = acc && (addr_i == OFF_EVT);
  assign evt_w1c   = wr_en_i && (addr_i == OFF_EVT);
  assign ee_wr[0]  = wr_en_i && (addr_i == OFF_EE0);
  assign ee_wr[1]  = wr_en_i && (addr_i == OFF_EE1);

  // power-good word: bay 0 always powered
  always_comb begin
    pwr_word = '0;
    for (int b = 0; b < NUM_BAYS; b++) begin
      if (b == 0 || card_present_i[b]) begin
        pwr_word[bay_pwr_lo(b)]   = 1'b1;
        pwr_word[bay_pwr_lo(b)+1] = 1'b1;
      end
    end
  end

  assign evt_set = {sram_err_i, oir_evt_i, 1'b0};

  mpsr_evt_status #(.W(EVT_W)) u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (evt_set),
    .w1c_i   (evt_w1c),
    .mask_i  (wdata_i[EVT_W-1:0]),
    .status_o(evt_status)
  );

  mpsr_irq_latch #(.W(1)) u_irq_netio (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (netio_evt_i),
    .clr_i (netio_clr),
    .irq_o (netio_irq_o)
  );

  mpsr_irq_latch #(.W(1)) u_irq_mgmt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (pa_mgmt_evt_i),
    .clr_i (mgmt_clr),
    .irq_o (pa_irq_o)
  );

  mpsr_irq_latch #(.W(EVT_W)) u_irq_oir (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_set),
    .clr_i (evt_acc),
    .irq_o (oir_irq_o)
  );

  mpsr_ee_ports u_ee (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_port_i(ee_wr),
    .wdata_i  (wdata_i),
    .dout_i   (ee_dout_i),
    .sel_o    (ee_sel_o),
    .clk_o    (ee_clk_o),
    .din_o    (ee_din_o),
    .rd_port_o(ee_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   ctrl_o <= '0;
    else if (wr_en_i && (addr_i == OFF_CTRL))      ctrl_o <= wdata_i;
  end

  always_comb begin
    if (is_netio_off(addr_i)) begin
      rd_mux = '1;
    end else begin
      case (addr_i)
        OFF_MGMT: rd_mux = pwr_word & MGMT_MASK;
        OFF_ONES: rd_mux = '1;
        OFF_PWR:  rd_mux = pwr_word;
        OFF_CTRL: rd_mux = ctrl_o;
        OFF_EE0:  rd_mux = ee_rd[0];
        OFF_EE1:  rd_mux = ee_rd[1];
        OFF_EVT:  rd_mux = {{(DATA_W-EVT_W){1'b0}}, evt_status};
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
    else              rdata_o <= '0;
  end
endmodule

// File: rtl/mpsr_chk.sv
module mpsr_chk
  import mpsr_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                wr_en_i,
  input logic                rd_en_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [NUM_BAYS-1:1] oir_evt_i,
  input logic                sram_err_i,
  input logic                netio_evt_i,
  input logic                pa_mgmt_evt_i,
  input logic                netio_irq_o,
  input logic                pa_irq_o,
  input logic                oir_irq_o,
  input logic [DATA_W-1:0]   ctrl_o,
  input logic [NUM_BAYS-1:0] ee_sel_o,
  input logic [NUM_BAYS-1:0] ee_clk_o,
  input logic [NUM_BAYS-1:0] ee_din_o
);
  logic mgmt_acc, evt_acc, ee_wr;
  assign mgmt_acc = (rd_en_i || wr_en_i) && addr_i == OFF_MGMT;
  assign evt_acc  = (rd_en_i || wr_en_i) && addr_i == OFF_EVT;
  assign ee_wr    = wr_en_i && (addr_i == OFF_EE0 || addr_i == OFF_EE1);

  p_idle_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rdata_o == '0);
  p_ones_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFF_ONES) |=> rdata_o == '1);
  p_bay0_pwr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFF_PWR) |=> rdata_o[2:1] == 2'b11);
  p_mgmt_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFF_MGMT) |=> (rdata_o & ~MGMT_MASK) == '0);
  p_mgmt_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgmt_acc && !pa_mgmt_evt_i) |=> !pa_irq_o);
  p_mgmt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pa_irq_o && !mgmt_acc) |=> pa_irq_o);
  p_oir_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_acc && !sram_err_i && oir_evt_i == '0) |=> !oir_irq_o);
  p_oir_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oir_irq_o && !evt_acc) |=> oir_irq_o);
  p_netio_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 8'h12 && !netio_evt_i) |=> !netio_irq_o);
  p_ctrl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_CTRL) |=> ctrl_o == $past(wdata_i));
  p_ee_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ee_wr |=> $stable({ee_sel_o, ee_clk_o, ee_din_o}));
endmodule

bind midplane_slot_regs mpsr_chk u_chk (.*);

// File: tb/midplane_slot_regs_tb.sv
`timescale 1ns/1ps
module midplane_slot_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:1]  card = '0, oir = '0;
  logic        sram = 1'b0, nio_evt = 1'b0, mgmt_evt = 1'b0;
  logic [6:0]  dout = '0;
  logic        nio_irq, pa_irq, oir_irq;
  logic [31:0] ctrl;
  logic [6:0]  sel, sk, din;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_q = 1'b0;

  always #2.5 clk = ~clk;

  midplane_slot_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .card_present_i(card), .oir_evt_i(oir),
    .sram_err_i(sram), .netio_evt_i(nio_evt), .pa_mgmt_evt_i(mgmt_evt),
    .ee_dout_i(dout), .netio_irq_o(nio_irq), .pa_irq_o(pa_irq), .oir_irq_o(oir_irq),
    .ctrl_o(ctrl), .ee_sel_o(sel), .ee_clk_o(sk), .ee_din_o(din)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data one cycle after each read strobe
  always @(posedge clk) rd_q <= rd_en;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_q) begin
        if (exp_q.size() == 0) begin
          n_vec++; n_bad++;
          $display("FAIL R12: actual %h expected no read data", rdata);
        end else begin
          check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
      end else begin
        check("R12 idle rdata", rdata, 32'h0);
      end
    end
  end

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irqs", {29'b0, nio_irq, pa_irq, oir_irq}, 32'h0);
    check("R1 ctrl", ctrl, 32'h0);
    check("R1 ee", {11'b0, sel, sk, din}, 32'h0);
    check("R1 rdata", rdata, 32'h0);

    // R2/R3 power-good and masked read
    bus_rd(8'h50, 32'h0000_0006, "R2 no cards");
    bus_rd(8'h40, 32'h0000_0000, "R3 no cards masked");
    card = 6'b111111;
    bus_rd(8'h50, 32'h6666_6606, "R2 all cards");
    bus_rd(8'h40, 32'h6666_6600, "R3 all cards masked");
    card = 6'b010100;
    bus_rd(8'h50, 32'h6600_0006, "R2 bays 3,5");
    bus_rd(8'h40, 32'h6600_0000, "R3 bays 3,5 masked");

    // R6/R3 management interrupt
    mgmt_evt = 1'b1; @(negedge clk); mgmt_evt = 1'b0;
    check("R6 mgmt set", pa_irq, 1'b1);
    repeat (3) @(negedge clk);
    bus_rd(8'h58, 32'h0, "R8 ctrl reads zero");
    check("R6 mgmt held", pa_irq, 1'b1);
    bus_wr(8'h40, 32'h0);
    check("R3 write clears mgmt", pa_irq, 1'b0);
    mgmt_evt = 1'b1; @(negedge clk);
    check("R6 mgmt set again", pa_irq, 1'b1);
    bus_rd(8'h40, 32'h6600_0000, "R3 read during level");
    check("R6 held level no re-set", pa_irq, 1'b0);
    mgmt_evt = 1'b0; @(negedge clk);
    // same-cycle rising event and clearing write
    mgmt_evt = 1'b1; addr = 8'h40; wr_en = 1'b1;
    @(negedge clk);
    mgmt_evt = 1'b0; wr_en = 1'b0;
    check("R6 event wins over mgmt clear", pa_irq, 1'b1);
    bus_rd(8'h40, 32'h6600_0000, "R3 read clears");
    check("R3 read clears mgmt", pa_irq, 1'b0);

    // R4/R5 event status
    oir[2] = 1'b1; sram = 1'b1; @(negedge clk); oir = '0; sram = 1'b0;
    check("R6 oir set", oir_irq, 1'b1);
    bus_rd(8'h70, 32'h0000_0084, "R4 status slot2+sram");
    check("R5 read clears oir irq", oir_irq, 1'b0);
    bus_rd(8'h70, 32'h0000_0084, "R4 read keeps status");
    bus_wr(8'h70, 32'h0000_0080);
    bus_rd(8'h70, 32'h0000_0004, "R5 w1c sram bit");
    oir[1] = 1'b1; @(negedge clk); oir = '0;
    check("R6 oir set slot1", oir_irq, 1'b1);
    bus_wr(8'h70, 32'h0000_0002);
    check("R5 write clears oir irq", oir_irq, 1'b0);
    // same-cycle event and w1c of the same bit
    oir[6] = 1'b1; addr = 8'h70; wdata = 32'h0000_0040; wr_en = 1'b1;
    @(negedge clk);
    oir = '0; wr_en = 1'b0;
    check("R6 event wins over oir clear", oir_irq, 1'b1);
    bus_rd(8'h70, 32'h0000_0044, "R5 new bit survives w1c");

    // R7 network I/O interrupt
    nio_evt = 1'b1; @(negedge clk); nio_evt = 1'b0;
    check("R7 netio set", nio_irq, 1'b1);
    bus_rd(8'h14, 32'h0, "R11 gap offset reads zero");
    check("R7 0x14 no clear", nio_irq, 1'b1);
    bus_rd(8'h1b, 32'h0, "R11 0x1b reads zero");
    check("R7 0x1b no clear", nio_irq, 1'b1);
    bus_rd(8'h12, 32'hFFFF_FFFF, "R7 0x12 ones");
    check("R7 0x12 clears", nio_irq, 1'b0);
    nio_evt = 1'b1; @(negedge clk); nio_evt = 1'b0;
    bus_rd(8'h1a, 32'hFFFF_FFFF, "R7 0x1a ones");
    check("R7 0x1a clears", nio_irq, 1'b0);
    bus_rd(8'h10, 32'hFFFF_FFFF, "R7 0x10 ones");

    // R8 control register
    bus_wr(8'h58, 32'hDEAD_BEEF);
    check("R8 ctrl_o", ctrl, 32'hDEAD_BEEF);
    bus_rd(8'h58, 32'hDEAD_BEEF, "R8 ctrl readback");

    // R9/R10 EEPROM ports
    bus_wr(8'h60, 32'h0208_0053);
    check("R9 sel after 0x60", {25'b0, sel}, 32'h09);
    check("R9 clk after 0x60", {25'b0, sk}, 32'h10);
    check("R9 din after 0x60", {25'b0, din}, 32'h01);
    bus_wr(8'h68, 32'h0850_0202);
    check("R9 sel after 0x68", {25'b0, sel}, 32'h0D);
    check("R9 clk after 0x68", {25'b0, sk}, 32'h30);
    check("R9 din after 0x68", {25'b0, din}, 32'h41);
    dout = 7'b0100010;
    bus_rd(8'h60, 32'h0208_4012, "R10 port 0x60 readback");
    bus_rd(8'h68, 32'h4810_0200, "R10 port 0x68 readback");
    dout = '0;

    // R11 misc offsets
    bus_rd(8'h48, 32'hFFFF_FFFF, "R11 0x48 ones");
    bus_wr(8'h78, 32'hFFFF_FFFF);
    bus_rd(8'h78, 32'h0, "R11 0x78 zero");
    check("R11 0x78 write no ctrl effect", ctrl, 32'hDEAD_BEEF);
    bus_rd(8'h70, 32'h0000_0044, "R11 0x78 write no status effect");
    bus_rd(8'h30, 32'h0, "R11 unmapped zero");
    bus_rd(8'h7b, 32'h0, "R11 0x7b zero");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) check("R12 drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule